// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns an instruction's effective offset into a 32-bit linear address, using the hidden base, limit and usable flag of whichever segment the surrounding logic has already picked. It also checks that the access stays inside the segment. A request carries the offset, an address-size flag, an access-size code and the segment fields. One clock later the result appears as a linear address and a fault flag.

In 16-bit addressing the offset is cut to its low 16 bits before the base is added. A multi-byte access that runs past the limit faults; it never wraps. The limit is taken as loaded, so a 4 GB limit permits 32-bit offsets even while the processor is otherwise in real mode.

Both edges of the block are valid/ready streams.
- The block accepts a request on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the one-entry output register is empty, or is being emptied in the same cycle (`out_ready` high).
- A producer that sees `in_ready` low must hold its request unchanged.
- While `out_valid` is high and `out_ready` is low, the result stays frozen.

Top module: `seg_agen`

## Requirements
- R1: When `in_addr32` is 0, only `in_offset[15:0]` is used as the effective offset. Its upper bits are ignored, so an offset of 0x00015000 acts as 0x5000.
- R2: `out_linear` equals `in_base` plus the effective offset, modulo 2^32.
- R3: The access-size code sets how many bytes are touched: 2'b00 is 1 byte, 2'b01 is 2 bytes, 2'b10 and 2'b11 are 4 bytes. `out_fault` is 1 when the last byte touched (effective offset + bytes − 1) is greater than `in_limit`.
- R4: An access whose last byte lands exactly on `in_limit` does not fault.
- R5: The last-byte sum is formed in 33 bits. A carry out of bit 31 is a fault, even when the limit is 0xFFFFFFFF.
- R6: When `in_usable` is 0, `out_fault` is 1 whatever the offset.
- R7: When `out_fault` is 1, `out_linear` is 0.
- R8: A request accepted on a clock edge shows up with `out_valid` high right after that edge. With no request accepted and the output consumed, `out_valid` falls.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and `out_linear`/`out_fault` keep their values.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_offset | input | 32 | Effective offset from address calculation |
| in_addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| in_size | input | 2 | Access size code (see R3) |
| in_base | input | 32 | Segment hidden base |
| in_limit | input | 32 | Segment limit (length minus one) |
| in_usable | input | 1 | Segment usable flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_linear | output | 32 | Linear address, 0 on fault |
| out_fault | output | 1 | Access violates limit or segment unusable |

## Verification
All the state sits in the single output register. A wrong value there shows up at the ports on the first sampling point after the accepting edge: a wrong linear address, a fault where none belongs, or a nonzero address beside a fault.

A broken stall path shows a different way. The result changes, or `in_ready` rises, while the consumer is still holding `out_ready` low, and this is visible within one cycle of the stall.

Limit errors are pinned down with accesses whose last byte sits exactly on the limit, one byte past it, straddling it, and carrying out of 32 bits.

// File: rtl/seg_agen_pkg.sv
package seg_agen_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned NARROW_W = 16;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'b00,
    ACC_WORD  = 2'b01,
    ACC_DWORD = 2'b10,
    ACC_DWALT = 2'b11
  } acc_size_e;

  // Bytes touched beyond the first one.
  function automatic logic [2:0] extra_bytes(input logic [1:0] code);
    case (code)
      ACC_BYTE: extra_bytes = 3'd0;
      ACC_WORD: extra_bytes = 3'd1;
      default:  extra_bytes = 3'd3;
    endcase
  endfunction
endpackage

// File: rtl/seg_offset_trim.sv
module seg_offset_trim #(
  parameter int unsigned OFS_W    = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic [OFS_W-1:0] raw_ofs,
  input  logic             wide,
  output logic [OFS_W-1:0] eff_ofs
);
  localparam int unsigned HI_W = OFS_W - NARROW_W;

  always_comb begin
    if (wide) eff_ofs = raw_ofs;
    else      eff_ofs = {{HI_W{1'b0}}, raw_ofs[NARROW_W-1:0]};
  end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_agen_pkg::*;
#(
  parameter int unsigned OFS_W = 32
) (
  input  logic [OFS_W-1:0] eff_ofs,
  input  logic [1:0]       size_code,
  input  logic [OFS_W-1:0] limit,
  input  logic             usable,
  output logic             violation
);
  localparam int unsigned SUM_W = OFS_W + 1;
  localparam int unsigned PAD_W = SUM_W - 3;

  logic [SUM_W-1:0] last_byte;
  logic             carry_out;
  logic             past_limit;

  always_comb begin
    last_byte  = {1'b0, eff_ofs} + {{PAD_W{1'b0}}, extra_bytes(size_code)};
    carry_out  = last_byte[SUM_W-1];
    past_limit = last_byte[OFS_W-1:0] > limit;
    violation  = !usable || carry_out || past_limit;
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          drain,
  input  logic [AW-1:0] nxt_lin,
  input  logic          nxt_fault,
  output logic          hold_valid,
  output logic [AW-1:0] hold_lin,
  output logic          hold_fault
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_lin   <= '0;
      hold_fault <= 1'b0;
    end else begin
      if (take) begin
        hold_valid <= 1'b1;
        hold_lin   <= nxt_fault ? '0 : nxt_lin;
        hold_fault <= nxt_fault;
      end else if (drain) begin
        hold_valid <= 1'b0;
      end
    end
  end

  // R7: a faulting result never carries an address
  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid && hold_fault |-> hold_lin == '0);

  // R9: a stalled result stays put
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid && !drain |=> hold_valid && $stable(hold_lin) && $stable(hold_fault));

  // R8: an accepted request is visible after the edge
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> hold_valid);
endmodule

// File: rtl/seg_agen.sv
module seg_agen
  import seg_agen_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NW = NARROW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_offset,
  input  logic          in_addr32,
  input  logic [1:0]    in_size,
  input  logic [AW-1:0] in_base,
  input  logic [AW-1:0] in_limit,
  input  logic          in_usable,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_linear,
  output logic          out_fault
);
  localparam int unsigned HI_W = AW - NW;

  logic [AW-1:0] eff_ofs;
  logic [AW-1:0] lin_sum;
  logic          viol;
  logic          take;

  seg_offset_trim #(.OFS_W(AW), .NARROW_W(NW)) u_trim (
    .raw_ofs (in_offset),
    .wide    (in_addr32),
    .eff_ofs (eff_ofs)
  );

  seg_limit_check #(.OFS_W(AW)) u_chk (
    .eff_ofs   (eff_ofs),
    .size_code (in_size),
    .limit     (in_limit),
    .usable    (in_usable),
    .violation (viol)
  );

  assign lin_sum  = in_base + eff_ofs;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  seg_out_stage #(.AW(AW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .drain      (out_ready),
    .nxt_lin    (lin_sum),
    .nxt_fault  (viol),
    .hold_valid (out_valid),
    .hold_lin   (out_linear),
    .hold_fault (out_fault)
  );

  // R1: in 16-bit mode only the low offset half reaches the address
  p_trunc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !in_addr32 && in_usable && (in_limit == '1)
    |=> out_linear == $past(in_base + {{HI_W{1'b0}}, in_offset[NW-1:0]}));

  // R6: an unusable segment always faults
  p_unusable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !in_usable |=> out_fault);

  // R5: a multi-byte access from the top offset carries out and faults
  p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_addr32 && (in_offset == '1) && (in_size != 2'b00) |=> out_fault);
endmodule

// File: tb/tb_seg_agen.sv
`timescale 1ns/1ps
module tb_seg_agen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_addr32, in_usable;
  logic [31:0] in_offset, in_base, in_limit;
  logic [1:0]  in_size;
  logic        out_valid, out_ready, out_fault;
  logic [31:0] out_linear;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  seg_agen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_offset(in_offset), .in_addr32(in_addr32), .in_size(in_size),
    .in_base(in_base), .in_limit(in_limit), .in_usable(in_usable),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_linear(out_linear), .out_fault(out_fault)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] ofs;
    logic        a32;
    logic [1:0]  sz;
    logic [31:0] base;
    logic [31:0] lim;
    logic        usable;
    logic        xfault;
    logic [31:0] xlin;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 32'h0001_5000, 1'b0, 2'b00, 32'h0000_1000, 32'h0000_FFFF, 1'b1, 1'b0, 32'h0000_6000}, // R1 sum truncated
    '{4'd2, 32'h0012_3456, 1'b1, 2'b10, 32'h1000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h1012_3456}, // R2
    '{4'd2, 32'h0000_0200, 1'b1, 2'b00, 32'hFFFF_FF00, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0000_0100}, // R2 wrap mod 2^32
    '{4'd3, 32'h0000_FFFF, 1'b0, 2'b01, 32'h0002_0000, 32'h0000_FFFF, 1'b1, 1'b1, 32'h0000_0000}, // R3 R7 word straddles 64K
    '{4'd3, 32'h0000_FFFF, 1'b0, 2'b01, 32'h0002_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0002_FFFF}, // R3 4G limit no fault
    '{4'd4, 32'h0001_FFFC, 1'b1, 2'b10, 32'h0000_0000, 32'h0001_FFFF, 1'b1, 1'b0, 32'h0001_FFFC}, // R4 dword ends on limit
    '{4'd3, 32'h0001_FFFD, 1'b1, 2'b10, 32'h0000_0000, 32'h0001_FFFF, 1'b1, 1'b1, 32'h0000_0000}, // R3 one past
    '{4'd4, 32'h0001_FFFF, 1'b1, 2'b00, 32'h0000_0100, 32'h0001_FFFF, 1'b1, 1'b0, 32'h0002_00FF}, // R4 byte on limit
    '{4'd3, 32'h0002_0000, 1'b1, 2'b00, 32'h0000_0100, 32'h0001_FFFF, 1'b1, 1'b1, 32'h0000_0000}, // R3 byte past
    '{4'd5, 32'hFFFF_FFFF, 1'b1, 2'b01, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'h0000_0000}, // R5 carry
    '{4'd5, 32'hFFFF_FFFC, 1'b1, 2'b10, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'hFFFF_FFFC}, // R5 no carry
    '{4'd6, 32'h0000_0000, 1'b0, 2'b00, 32'h0000_4000, 32'h0000_FFFF, 1'b0, 1'b1, 32'h0000_0000}, // R6
    '{4'd3, 32'h0010_0000, 1'b1, 2'b00, 32'h0000_0000, 32'h0000_FFFF, 1'b1, 1'b1, 32'h0000_0000}, // R3 32-bit ofs vs 64K
    '{4'd3, 32'h0000_FFFC, 1'b0, 2'b11, 32'h0000_0000, 32'h0000_FFFF, 1'b1, 1'b0, 32'h0000_FFFC}  // R3 code 11 = 4 bytes
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid  = 1'b1;
    in_offset = v.ofs;
    in_addr32 = v.a32;
    in_size   = v.sz;
    in_base   = v.base;
    in_limit  = v.lim;
    in_usable = v.usable;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_offset = '0; in_addr32 = 1'b0; in_size = 2'b00;
    in_base = '0; in_limit = '0; in_usable = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R10 in_ready", {31'b0, in_ready}, 32'd1);

    // table walk, one request per cycle, consumer always ready
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d valid", VEC[i].req, i), {31'b0, out_valid}, 32'd1);
      chk($sformatf("R%0d vec%0d fault", VEC[i].req, i), {31'b0, out_fault}, {31'b0, VEC[i].xfault});
      chk($sformatf("R%0d vec%0d linear", VEC[i].req, i), out_linear, VEC[i].xlin);
    end

    // R8: idle drains the output
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 valid drops", {31'b0, out_valid}, 32'd0);

    // R9: stall holds result and blocks input
    out_ready = 1'b0;
    drive(VEC[1]);
    @(negedge clk);
    chk("R8 latency", {31'b0, out_valid}, 32'd1);
    drive(VEC[3]);
    @(negedge clk);
    chk("R9 in_ready low", {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R9 linear held", out_linear, VEC[1].xlin);
    chk("R9 fault held", {31'b0, out_fault}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 next taken fault", {31'b0, out_fault}, 32'd1);
    chk("R7 next taken linear", out_linear, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 drained", {31'b0, out_valid}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule